// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Sequencer

This block produces the address for the sequential port of an 8K-word memory that is split into two programmable regions. A 13-bit pointer advances on the sequential clock while the sequential enable is high. Each region has a first address, a last address and a flow mode. The flow mode decides what the pointer does when it reaches the region's last address. It can jump to the first address of the other region, hold where it is, keep counting and raise a flag, or keep counting without any flag.

A command port with random access lets a host program both regions and the mode register. The same port reads the flag status and clears the active-low end-of-region flags. Writes take effect on the sequential clock edge. Reads are combinational. An asynchronous reset restores the power-up layout: each region covers one half of the address space, both regions use jump mode, and the pointer is at zero.

Top module: `dual_buf_seq`

## Requirements
- R1: Reset gives these values: pointer 0, both `eob_n` bits 1, both modes jump (00), region 1 from 0 to 4095, region 2 from 4096 to 8191.
- R2: A command write with code 000, 001, 010 or 011 loads data bits 12:0 into, in that order, region 1 first, region 1 last, region 2 first and region 2 last. Data bits 15:13 are ignored. A read of the same code returns the 13-bit value with bits 15:13 at zero.
- R3: Code 100 holds the modes. Region 1 uses bits 1:0 and region 2 uses bits 3:2. The encoding is 00 jump, 01 hold, 10 run-flagged and 11 run-silent. A read returns zero in bits 15:4.
- R4: A write with code 101 clears the flag of region 1 when data bit 0 is 1 and the flag of region 2 when data bit 1 is 1. A read with code 101 returns a 1 in bit 0 (region 1) and in bit 1 (region 2) for each flag that is active (its `eob_n` bit low), and zero in all other bits.
- R5: Writes to codes 110 and 111 change nothing. Reads of these codes return 0.
- R6: The pointer changes only on a rising `clk` edge while `seq_en` is 1. Otherwise it holds.
- R7: In jump mode, an enabled step from the region's last address sets that region's flag and loads the first address of the other region.
- R8: In hold mode, the pointer stays at the region's last address and no flag is set.
- R9: In run-flagged mode, the pointer steps past the last address and sets the region's flag. The pointer wraps from 8191 to 0.
- R10: Run-silent mode steps like run-flagged mode but never sets a flag.
- R11: The region whose settings apply is region 2 when the pointer lies within region 2's first..last range. In every other case it is region 1.
- R12: When a flag clear and a flag set fall on the same edge, the flag ends up set.
- R13: Reset acts at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequential clock |
| rst | input | 1 | Asynchronous reset, active high |
| seq_en | input | 1 | Pointer step enable |
| cmd_sel | input | 1 | Command access strobe |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | Command code |
| cmd_wdata | input | 16 | Command write data |
| cmd_rdata | output | 16 | Command read data (0 when no read is in progress) |
| ptr | output | 13 | Current sequential address |
| eob_n | output | 2 | Active-low end-of-region flags, bit 0 = region 1 |

## Verification
The bench drives the pointer across a region boundary in each of the four modes. A design that ignores the mode would run past the end in hold mode, or would raise a flag in run-silent mode. The bench walks the 8191-to-0 wrap in run-flagged mode, where an adder of the wrong width would not wrap. It places a jump at a region's end on the same edge as a flag clear, where the wrong priority would lose the flag. It also selects region 2's settings while a different region 1 is programmed, so a design that checks only region 1's last address would never jump. Finally it raises reset in the middle of a cycle, and a synchronous reset would leave the pointer unchanged there.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    parameter int AW   = 13;
    parameter int DW   = 16;
    parameter int NBUF = 2;
    localparam int HALF = 2 ** (AW - 1);

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [1:0] {
        FLOW_JUMP   = 2'b00,
        FLOW_HOLD   = 2'b01,
        FLOW_RUNFLG = 2'b10,
        FLOW_RUNSIL = 2'b11
    } flow_e;

    typedef enum logic [2:0] {
        CMD_FIRST1 = 3'b000,
        CMD_LAST1  = 3'b001,
        CMD_FIRST2 = 3'b010,
        CMD_LAST2  = 3'b011,
        CMD_MODE   = 3'b100,
        CMD_FLAG   = 3'b101
    } cmd_e;

    typedef struct packed {
        addr_t first;
        addr_t last;
        flow_e mode;
    } buf_cfg_t;

    function automatic logic in_span(addr_t p, buf_cfg_t c);
        return (p >= c.first) && (p <= c.last);
    endfunction

    function automatic buf_cfg_t cfg_default(int b);
        buf_cfg_t c;
        c.first = addr_t'(b * HALF);
        c.last  = addr_t'((b + 1) * HALF - 1);
        c.mode  = FLOW_JUMP;
        return c;
    endfunction
endpackage

// File: rtl/dbs_regs.sv
module dbs_regs
    import dbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_sel,
    input  logic                 cmd_wr,
    input  logic [2:0]           cmd_addr,
    input  logic [DW-1:0]        cmd_wdata,
    input  logic [NBUF-1:0]      hit,
    output buf_cfg_t [NBUF-1:0]  cfg,
    output logic [NBUF-1:0]      clr_req,
    output logic [DW-1:0]        cmd_rdata
);
    logic  wr_en;
    logic  rd_en;
    addr_t wval;

    assign wr_en = cmd_sel & cmd_wr;
    assign rd_en = cmd_sel & ~cmd_wr;
    assign wval  = cmd_wdata[AW-1:0];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int b = 0; b < NBUF; b++) cfg[b] <= cfg_default(b);
        end else if (wr_en) begin
            for (int b = 0; b < NBUF; b++) begin
                if (cmd_addr == 3'(2 * b))     cfg[b].first <= wval;
                if (cmd_addr == 3'(2 * b + 1)) cfg[b].last  <= wval;
                if (cmd_addr == CMD_MODE)      cfg[b].mode  <= flow_e'(cmd_wdata[2*b +: 2]);
            end
        end
    end

    assign clr_req = (wr_en && cmd_addr == CMD_FLAG) ? cmd_wdata[NBUF-1:0] : '0;

    always_comb begin
        cmd_rdata = '0;
        if (rd_en) begin
            case (cmd_addr)
                CMD_FIRST1: cmd_rdata = DW'(cfg[0].first);
                CMD_LAST1:  cmd_rdata = DW'(cfg[0].last);
                CMD_FIRST2: cmd_rdata = DW'(cfg[1].first);
                CMD_LAST2:  cmd_rdata = DW'(cfg[1].last);
                CMD_MODE:   cmd_rdata = DW'({cfg[1].mode, cfg[0].mode});
                CMD_FLAG:   cmd_rdata = DW'(hit);
                default:    cmd_rdata = '0;
            endcase
        end
    end

    // R2
    first1_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_addr == CMD_FIRST1) |=> cfg[0].first == $past(wval));

    // R5
    reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_addr[2:1] == 2'b11) |=> $stable(cfg));
endmodule

// File: rtl/dbs_ptr.sv
module dbs_ptr
    import dbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seq_en,
    input  buf_cfg_t [NBUF-1:0]  cfg,
    output addr_t                ptr,
    output logic [NBUF-1:0]      set_req
);
    addr_t ptr_q;
    addr_t ptr_d;
    logic  act;
    logic  oth;
    logic  at_end;
    flow_e mode;

    assign act    = in_span(ptr_q, cfg[1]);
    assign oth    = ~act;
    assign at_end = (ptr_q == cfg[act].last);
    assign mode   = cfg[act].mode;

    always_comb begin
        ptr_d   = ptr_q;
        set_req = '0;
        if (seq_en) begin
            unique case (mode)
                FLOW_JUMP: begin
                    if (at_end) begin
                        ptr_d        = cfg[oth].first;
                        set_req[act] = 1'b1;
                    end else begin
                        ptr_d = ptr_q + addr_t'(1);
                    end
                end
                FLOW_HOLD: begin
                    if (!at_end) ptr_d = ptr_q + addr_t'(1);
                end
                FLOW_RUNFLG: begin
                    ptr_d        = ptr_q + addr_t'(1);
                    set_req[act] = at_end;
                end
                FLOW_RUNSIL: ptr_d = ptr_q + addr_t'(1);
                default:     ptr_d = ptr_q;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !seq_en |=> $stable(ptr_q));

    // R8
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_en && at_end && mode == FLOW_HOLD) |=> $stable(ptr_q));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_en && at_end && mode == FLOW_JUMP) |=> ptr_q == $past(cfg[oth].first));

    // R10
    silent_step_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_en && mode == FLOW_RUNSIL) |=> ptr_q == addr_t'($past(ptr_q) + addr_t'(1)));
endmodule

// File: rtl/dbs_flags.sv
module dbs_flags
    import dbs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NBUF-1:0] set_req,
    input  logic [NBUF-1:0] clr_req,
    output logic [NBUF-1:0] hit
);
    for (genvar b = 0; b < NBUF; b++) begin : g_flag
        logic q;
        always_ff @(posedge clk or posedge rst) begin
            if (rst)             q <= 1'b0;
            else if (set_req[b]) q <= 1'b1;
            else if (clr_req[b]) q <= 1'b0;
        end
        assign hit[b] = q;

        // R12
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_req[b] |=> hit[b]);

        // R4
        clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_req[b] && !set_req[b]) |=> !hit[b]);
    end
endmodule

// File: rtl/dual_buf_seq.sv
module dual_buf_seq
    import dbs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          seq_en,
    input  logic          cmd_sel,
    input  logic          cmd_wr,
    input  logic [2:0]    cmd_addr,
    input  logic [15:0]   cmd_wdata,
    output logic [15:0]   cmd_rdata,
    output logic [12:0]   ptr,
    output logic [1:0]    eob_n
);
    buf_cfg_t [NBUF-1:0] cfg;
    logic [NBUF-1:0]     hit;
    logic [NBUF-1:0]     set_req;
    logic [NBUF-1:0]     clr_req;

    dbs_regs u_regs (
        .clk(clk), .rst(rst), .cmd_sel(cmd_sel), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .hit(hit),
        .cfg(cfg), .clr_req(clr_req), .cmd_rdata(cmd_rdata)
    );

    dbs_ptr u_ptr (
        .clk(clk), .rst(rst), .seq_en(seq_en), .cfg(cfg),
        .ptr(ptr), .set_req(set_req)
    );

    dbs_flags u_flags (
        .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req), .hit(hit)
    );

    assign eob_n = ~hit;

    // R13
    reset_state_chk: assert property (@(posedge clk) rst |-> (ptr == '0 && eob_n == 2'b11));
endmodule

// File: tb/sim_dual_buf_seq.sv
module sim_dual_buf_seq;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        seq_en = 0;
    logic        cmd_sel = 0;
    logic        cmd_wr = 0;
    logic [2:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] cmd_rdata;
    logic [12:0] ptr;
    logic [1:0]  eob_n;

    int total = 0;
    int bad = 0;
    logic [15:0] rv;

    // {code, write data, expected readback}
    localparam logic [34:0] VEC [6] = '{
        {3'b000, 16'hE123, 16'h0123},
        {3'b001, 16'h1FFF, 16'h1FFF},
        {3'b010, 16'h0010, 16'h0010},
        {3'b011, 16'hFFFF, 16'h1FFF},
        {3'b100, 16'hFFF6, 16'h0006},
        {3'b110, 16'h1234, 16'h0000}
    };

    dual_buf_seq u0 (
        .clk(clk), .rst(rst), .seq_en(seq_en), .cmd_sel(cmd_sel), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .ptr(ptr), .eob_n(eob_n)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_sel = 1; cmd_wr = 1; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_sel = 0; cmd_wr = 0;
    endtask

    task automatic cmd_read(input logic [2:0] a, output logic [15:0] d);
        cmd_sel = 1; cmd_wr = 0; cmd_addr = a;
        #1 d = cmd_rdata;
        cmd_sel = 0;
    endtask

    task automatic step(input int n);
        @(negedge clk);
        seq_en = 1;
        repeat (n) @(negedge clk);
        seq_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #(PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R2 R3 R5: table of write/readback pairs
        for (int i = 0; i < 6; i++) begin
            cmd_write(VEC[i][34:32], VEC[i][31:16]);
            cmd_read(VEC[i][34:32], rv);
            check($sformatf("R2/R3/R5 vec%0d", i), rv, VEC[i][15:0]);
        end
        cmd_write(3'b111, 16'hFFFF);
        cmd_read(3'b100, rv);
        check("R5 reserved write no effect", rv, 16'h0006);

        do_reset();
        // R1 defaults
        check("R1 ptr", ptr, 0);
        check("R1 eob_n", eob_n, 2'b11);
        cmd_read(3'b000, rv); check("R1 first1", rv, 0);
        cmd_read(3'b001, rv); check("R1 last1", rv, 4095);
        cmd_read(3'b010, rv); check("R1 first2", rv, 4096);
        cmd_read(3'b011, rv); check("R1 last2", rv, 8191);
        cmd_read(3'b100, rv); check("R1 modes", rv, 0);

        // R6 idle then stepping
        repeat (3) @(negedge clk);
        check("R6 idle hold", ptr, 0);
        step(5);
        check("R6 five steps", ptr, 5);

        // R7 jump from region 1 end into region 2
        cmd_write(3'b001, 16'd7);
        step(3);
        check("R7 jump ptr", ptr, 4096);
        check("R7 flag1", eob_n, 2'b10);
        cmd_read(3'b101, rv); check("R4 status one", rv, 16'h0001);

        // R11 region 2 settings apply at 4096..4097
        cmd_write(3'b011, 16'd4097);
        step(2);
        check("R11 jump back ptr", ptr, 0);
        check("R11 flag2", eob_n, 2'b00);
        cmd_read(3'b101, rv); check("R4 status both", rv, 16'h0003);

        // R4 selective clears
        cmd_write(3'b101, 16'hFFF1);
        check("R4 clear bit0", eob_n, 2'b01);
        cmd_write(3'b101, 16'h0002);
        check("R4 clear bit1", eob_n, 2'b11);

        // R8 hold mode
        cmd_write(3'b100, 16'h0001);
        step(10);
        check("R8 hold ptr", ptr, 7);
        check("R8 no flag", eob_n, 2'b11);

        // R9 run-flagged past end
        cmd_write(3'b100, 16'h0002);
        step(1);
        check("R9 past end ptr", ptr, 8);
        check("R9 flag", eob_n, 2'b10);

        // R9 wrap 8191 -> 0
        cmd_write(3'b101, 16'h0003);
        cmd_write(3'b010, 16'd8190);
        cmd_write(3'b011, 16'd8191);
        cmd_write(3'b100, 16'h0008);
        cmd_write(3'b001, 16'd9);
        step(4);
        check("R9 wrap ptr", ptr, 0);
        check("R9 wrap flags", eob_n, 2'b00);

        // R10 run-silent
        cmd_write(3'b101, 16'h0003);
        cmd_write(3'b100, 16'h000C);
        cmd_write(3'b001, 16'd0);
        step(3);
        check("R10 silent ptr", ptr, 0);
        check("R10 no flag2", eob_n, 2'b10);

        // R12 set and clear on one edge
        cmd_write(3'b101, 16'h0003);
        check("R4 cleared before R12", eob_n, 2'b11);
        @(negedge clk);
        seq_en = 1; cmd_sel = 1; cmd_wr = 1; cmd_addr = 3'b101; cmd_wdata = 16'h0003;
        @(negedge clk);
        seq_en = 0; cmd_sel = 0; cmd_wr = 0;
        check("R12 set wins", eob_n, 2'b10);
        check("R12 ptr", ptr, 8190);

        // R13 reset mid-cycle
        @(negedge clk);
        #2 rst = 1;
        #1;
        check("R13 async ptr", ptr, 0);
        check("R13 async eob_n", eob_n, 2'b11);
        cmd_read(3'b001, rv); check("R13 async last1", rv, 4095);
        @(negedge clk);
        rst = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule